// File: doc/BRIEF.md
# Two-Sided Sync Byte Mailbox

The block joins two processors, side A and side B, through one 32-bit sync register per side. Each side writes an 8-bit byte that it offers to its peer. It reads the byte its peer offers in a read-only field of its own register. Each side also holds a local interrupt enable. Two write-only trigger bits let either side request an interrupt on side A or on side B, and a side may target itself. A request is taken only when the target side's enable is set at that moment. A request that is taken stays pending until that side pulses its acknowledge input.

Each side has its own write port with four byte-lane strobes, so software can write the register as four single bytes or as one 32-bit word. Read data is always present and needs no strobe. Each side has one interrupt output. That output is high while the side's request is pending and its enable is set.

The pending condition of each side is a two-state machine. The states are `IRQ_IDLE` (nothing pending) and `IRQ_PEND` (a taken request waits for acknowledge). There are two transitions. *take* goes from `IRQ_IDLE` to `IRQ_PEND` when a trigger aimed at the side arrives while its enable is set. *clear* goes from `IRQ_PEND` to `IRQ_IDLE` when acknowledge is high and no request is taken in the same cycle. In every other case the state holds.

Top module: `ipc_sync_mbox`

## Requirements
- R1: After reset, both read words are 0 and both interrupt outputs are low.
- R2: A write with lane strobe 1 stores data bits 15:8 as the side's outgoing byte. That byte reads back in bits 15:8 from the cycle after the write edge.
- R3: Bits 7:0 of each side's read word always equal bits 15:8 of the other side's read word.
- R4: Lanes 0 and 2 ignore writes. A write without lane strobe 1 leaves the outgoing byte unchanged, and a write without lane strobe 3 leaves the enable unchanged.
- R5: Bit 31 is the local interrupt enable. A write with lane strobe 3 loads it from data bit 31.
- R6: Bits 30:16 always read 0. This covers the reserved bit 23 and the trigger bits 29 and 30.
- R7: A write with lane strobe 3 and data bit 30 set, from either side, moves side A to `IRQ_PEND` at that edge, provided A's enable was set before the edge.
- R8: A write with lane strobe 3 and data bit 29 set, from either side, does the same for side B, gated by B's enable.
- R9: A trigger that arrives while the target's enable is clear is discarded. Setting the enable later does not raise the interrupt.
- R10: The interrupt output equals "state is `IRQ_PEND`" AND enable. Clearing the enable masks a pending interrupt, and setting the enable again shows it.
- R11: Acknowledge moves a side from `IRQ_PEND` to `IRQ_IDLE` at the next edge. If a taken trigger arrives in the same cycle, the trigger wins.
- R12: Triggers aimed at one side by both sides in the same cycle, or by a side at itself, are taken like any other trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_wr_en | input | 1 | Side A write valid |
| a_wr_be | input | 4 | Side A byte-lane write strobes |
| a_wr_data | input | 32 | Side A write data |
| a_irq_ack | input | 1 | Side A acknowledge, clears its pending request |
| a_rd_data | output | 32 | Side A register read value |
| a_irq | output | 1 | Side A interrupt |
| b_wr_en | input | 1 | Side B write valid |
| b_wr_be | input | 4 | Side B byte-lane write strobes |
| b_wr_data | input | 32 | Side B write data |
| b_irq_ack | input | 1 | Side B acknowledge |
| b_rd_data | output | 32 | Side B register read value |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench targets several corner cases, each chosen to catch a specific class of defect:

- **Trigger while disabled, then enable.** A design that latches requests regardless of the enable would raise the interrupt as soon as the enable is set.
- **Acknowledge and trigger in the same cycle.** A design that gives acknowledge the priority would drop an interrupt.
- **Narrow writes.** Single-lane writes to lanes 0 and 2, and full-word writes with bit 23 and bits 7:0 set, expose any lane decode that stores ignored bits or mirrors the wrong byte.
- **Self-targeted and simultaneous triggers.** These catch a source-to-target map that is crossed or that lets one request overwrite another.
- **Random traffic.** A long stretch of random writes and acknowledges is compared every cycle against a behavioural model.

// File: rtl/ipc_sync_pkg.sv
package ipc_sync_pkg;
    localparam int SYNC_BYTE_W = 8;
    localparam int LANES       = 4;
    localparam int REG_W       = LANES * SYNC_BYTE_W;
    localparam int NUM_SIDES   = 2;

    localparam int PEER_LANE   = 0;
    localparam int OWN_LANE    = 1;
    localparam int CTRL_LANE   = 3;

    localparam int TRIG_B_BIT  = 29;
    localparam int TRIG_A_BIT  = 30;
    localparam int EN_BIT      = 31;
    localparam int ZERO_W      = REG_W - 1 - 2 * SYNC_BYTE_W;

    typedef enum logic [0:0] {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/ipc_sync_side.sv
module ipc_sync_side
    import ipc_sync_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [LANES-1:0]       wr_be,
    input  logic [REG_W-1:0]       wr_data,
    output logic [SYNC_BYTE_W-1:0] own_byte,
    output logic                   irq_en,
    output logic [NUM_SIDES-1:0]   trig_to
);
    logic ctrl_wr;
    logic own_wr;

    assign ctrl_wr = wr_en && wr_be[CTRL_LANE];
    assign own_wr  = wr_en && wr_be[OWN_LANE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_byte <= '0;
            irq_en   <= 1'b0;
        end else begin
            if (own_wr) begin
                own_byte <= wr_data[OWN_LANE*SYNC_BYTE_W +: SYNC_BYTE_W];
            end
            if (ctrl_wr) begin
                irq_en <= wr_data[EN_BIT];
            end
        end
    end

    // one request line per target side; side 0 uses bit 30, side 1 bit 29
    for (genvar t = 0; t < NUM_SIDES; t++) begin : g_trig
        localparam int TBIT = (t == 0) ? TRIG_A_BIT : TRIG_B_BIT;
        assign trig_to[t] = ctrl_wr && wr_data[TBIT];
    end

    logic unused_lane_bits;
    assign unused_lane_bits = ^{wr_data[PEER_LANE*SYNC_BYTE_W +: SYNC_BYTE_W],
                                wr_data[TRIG_B_BIT-1:2*SYNC_BYTE_W],
                                wr_be[PEER_LANE], wr_be[2]};
endmodule

// File: rtl/ipc_sync_irq_fsm.sv
module ipc_sync_irq_fsm
    import ipc_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic irq_en,
    input  logic ack,
    output logic irq
);
    irq_state_e state_q;
    irq_state_e state_d;
    logic       take;

    assign take = trig && irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (take) state_d = IRQ_PEND;
            IRQ_PEND: if (ack && !take) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_PEND) && irq_en;
    end
endmodule

// File: rtl/ipc_sync_readmux.sv
module ipc_sync_readmux
    import ipc_sync_pkg::*;
(
    input  logic [SYNC_BYTE_W-1:0] own_byte,
    input  logic [SYNC_BYTE_W-1:0] peer_byte,
    input  logic                   irq_en,
    output logic [REG_W-1:0]       rd_data
);
    assign rd_data = {irq_en, {ZERO_W{1'b0}}, own_byte, peer_byte};
endmodule

// File: rtl/ipc_sync_mbox.sv
module ipc_sync_mbox
    import ipc_sync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_wr_en,
    input  logic [LANES-1:0] a_wr_be,
    input  logic [REG_W-1:0] a_wr_data,
    input  logic             a_irq_ack,
    output logic [REG_W-1:0] a_rd_data,
    output logic             a_irq,
    input  logic             b_wr_en,
    input  logic [LANES-1:0] b_wr_be,
    input  logic [REG_W-1:0] b_wr_data,
    input  logic             b_irq_ack,
    output logic [REG_W-1:0] b_rd_data,
    output logic             b_irq
);
    logic [NUM_SIDES-1:0]   wr_en_v;
    logic [NUM_SIDES-1:0]   ack_v;
    logic [NUM_SIDES-1:0]   irq_v;
    logic [NUM_SIDES-1:0]   en_v;
    logic [NUM_SIDES-1:0]   trig_dst;
    logic [LANES-1:0]       be_v   [NUM_SIDES];
    logic [REG_W-1:0]       wd_v   [NUM_SIDES];
    logic [REG_W-1:0]       rd_v   [NUM_SIDES];
    logic [SYNC_BYTE_W-1:0] own_v  [NUM_SIDES];
    logic [NUM_SIDES-1:0]   trig_src [NUM_SIDES];

    assign wr_en_v = {b_wr_en, a_wr_en};
    assign ack_v   = {b_irq_ack, a_irq_ack};
    assign be_v[0] = a_wr_be;
    assign be_v[1] = b_wr_be;
    assign wd_v[0] = a_wr_data;
    assign wd_v[1] = b_wr_data;

    // merge requests from every source per target
    always_comb begin
        for (int d = 0; d < NUM_SIDES; d++) begin
            trig_dst[d] = 1'b0;
            for (int s = 0; s < NUM_SIDES; s++) begin
                trig_dst[d] = trig_dst[d] | trig_src[s][d];
            end
        end
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam int PEER = NUM_SIDES - 1 - s;

        ipc_sync_side side_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en_v[s]),
            .wr_be    (be_v[s]),
            .wr_data  (wd_v[s]),
            .own_byte (own_v[s]),
            .irq_en   (en_v[s]),
            .trig_to  (trig_src[s])
        );

        ipc_sync_irq_fsm fsm_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig   (trig_dst[s]),
            .irq_en (en_v[s]),
            .ack    (ack_v[s]),
            .irq    (irq_v[s])
        );

        ipc_sync_readmux rmux_i (
            .own_byte  (own_v[s]),
            .peer_byte (own_v[PEER]),
            .irq_en    (en_v[s]),
            .rd_data   (rd_v[s])
        );
    end

    assign a_rd_data = rd_v[0];
    assign b_rd_data = rd_v[1];
    assign a_irq     = irq_v[0];
    assign b_irq     = irq_v[1];
endmodule

module ipc_sync_mbox_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        a_wr_en,
    input logic [3:0]  a_wr_be,
    input logic [31:0] a_wr_data,
    input logic        a_irq_ack,
    input logic [31:0] a_rd_data,
    input logic        a_irq,
    input logic        b_wr_en,
    input logic [3:0]  b_wr_be,
    input logic [31:0] b_wr_data,
    input logic        b_irq_ack,
    input logic [31:0] b_rd_data,
    input logic        b_irq
);
    logic trig_a;
    logic trig_b;
    logic unused_chk;

    assign trig_a = (a_wr_en && a_wr_be[3] && a_wr_data[30]) ||
                    (b_wr_en && b_wr_be[3] && b_wr_data[30]);
    assign trig_b = (a_wr_en && a_wr_be[3] && a_wr_data[29]) ||
                    (b_wr_en && b_wr_be[3] && b_wr_data[29]);
    assign unused_chk = ^{a_wr_be[2], a_wr_be[0], b_wr_be[2], b_wr_be[0],
                          a_wr_data[28:16], a_wr_data[7:0],
                          b_wr_data[28:16], b_wr_data[7:0]};

    // R3
    mirror_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_rd_data[7:0] == b_rd_data[15:8]);
    // R3
    mirror_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_rd_data[7:0] == a_rd_data[15:8]);
    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd_data[30:16] == 15'd0) && (b_rd_data[30:16] == 15'd0));
    // R2
    own_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_wr_be[1]) |=> (a_rd_data[15:8] == $past(a_wr_data[15:8])));
    // R4
    own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_wr_en && b_wr_be[1]) |=> $stable(b_rd_data[15:8]));
    // R5
    en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_wr_be[3]) |=> (a_rd_data[31] == $past(a_wr_data[31])));
    // R7
    take_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_a && a_rd_data[31]) |=> (a_irq || !a_rd_data[31]));
    // R8
    take_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_b && b_rd_data[31]) |=> (b_irq || !b_rd_data[31]));
    // R10
    gate_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_irq |-> a_rd_data[31]);
    // R10
    gate_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_irq |-> b_rd_data[31]);
    // R11
    ack_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_irq_ack && !(trig_a && a_rd_data[31])) |=> !a_irq);
    // R9
    rise_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_irq) |-> ($past(trig_b && b_rd_data[31]) || $rose(b_rd_data[31])));
endmodule

bind ipc_sync_mbox ipc_sync_mbox_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_wr_en   (a_wr_en),
    .a_wr_be   (a_wr_be),
    .a_wr_data (a_wr_data),
    .a_irq_ack (a_irq_ack),
    .a_rd_data (a_rd_data),
    .a_irq     (a_irq),
    .b_wr_en   (b_wr_en),
    .b_wr_be   (b_wr_be),
    .b_wr_data (b_wr_data),
    .b_irq_ack (b_irq_ack),
    .b_rd_data (b_rd_data),
    .b_irq     (b_irq)
);

// File: tb/ipc_sync_mbox_tb.sv
module ipc_sync_mbox_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr_en = 1'b0, b_wr_en = 1'b0;
    logic [3:0]  a_wr_be = '0, b_wr_be = '0;
    logic [31:0] a_wr_data = '0, b_wr_data = '0;
    logic        a_irq_ack = 1'b0, b_irq_ack = 1'b0;
    logic [31:0] a_rd_data, b_rd_data;
    logic        a_irq, b_irq;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    logic [7:0] m_out  [2];
    bit         m_en   [2];
    bit         m_pend [2];

    always #2.5 clk = ~clk;

    ipc_sync_mbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_wr_be(a_wr_be), .a_wr_data(a_wr_data),
        .a_irq_ack(a_irq_ack), .a_rd_data(a_rd_data), .a_irq(a_irq),
        .b_wr_en(b_wr_en), .b_wr_be(b_wr_be), .b_wr_data(b_wr_data),
        .b_irq_ack(b_irq_ack), .b_rd_data(b_rd_data), .b_irq(b_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int s);
        return {m_en[s], 15'd0, m_out[s], m_out[1-s]};
    endfunction

    task automatic model_step();
        bit trg [2];
        trg[0] = (a_wr_en && a_wr_be[3] && a_wr_data[30]) ||
                 (b_wr_en && b_wr_be[3] && b_wr_data[30]);
        trg[1] = (a_wr_en && a_wr_be[3] && a_wr_data[29]) ||
                 (b_wr_en && b_wr_be[3] && b_wr_data[29]);
        for (int s = 0; s < 2; s++) begin
            bit ack = (s == 0) ? a_irq_ack : b_irq_ack;
            if (trg[s] && m_en[s]) m_pend[s] = 1'b1;
            else if (ack)          m_pend[s] = 1'b0;
        end
        if (a_wr_en && a_wr_be[1]) m_out[0] = a_wr_data[15:8];
        if (b_wr_en && b_wr_be[1]) m_out[1] = b_wr_data[15:8];
        if (a_wr_en && a_wr_be[3]) m_en[0] = a_wr_data[31];
        if (b_wr_en && b_wr_be[3]) m_en[1] = b_wr_data[31];
    endtask

    task automatic compare_all();
        check(cur_req, "a_rd_data", a_rd_data, exp_rd(0));
        check(cur_req, "b_rd_data", b_rd_data, exp_rd(1));
        check(cur_req, "a_irq", {31'd0, a_irq}, {31'd0, m_pend[0] && m_en[0]});
        check(cur_req, "b_irq", {31'd0, b_irq}, {31'd0, m_pend[1] && m_en[1]});
    endtask

    task automatic cyc(input logic aw, input logic [3:0] abe, input logic [31:0] ad,
                       input logic aa, input logic bw, input logic [3:0] bbe,
                       input logic [31:0] bd, input logic ba);
        a_wr_en = aw; a_wr_be = abe; a_wr_data = ad; a_irq_ack = aa;
        b_wr_en = bw; b_wr_be = bbe; b_wr_data = bd; b_irq_ack = ba;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic a_wr(input logic [3:0] be, input logic [31:0] d);
        cyc(1'b1, be, d, 1'b0, 1'b0, 4'h0, 32'h0, 1'b0);
    endtask

    task automatic b_wr(input logic [3:0] be, input logic [31:0] d);
        cyc(1'b0, 4'h0, 32'h0, 1'b0, 1'b1, be, d, 1'b0);
    endtask

    task automatic idle();
        cyc(1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 4'h0, 32'h0, 1'b0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #500us;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_out[s] = '0; m_en[s] = 1'b0; m_pend[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R1", "a_rd_data in reset", a_rd_data, 32'h0);
        check("R1", "b_rd_data in reset", b_rd_data, 32'h0);
        check("R1", "irq in reset", {30'd0, a_irq, b_irq}, 32'h0);
        rst_n = 1'b1;
        idle();

        cur_req = "R2 R3 own byte and mirror";
        a_wr(4'b0010, 32'h0000_5A00);
        check("R2", "a own byte", {24'd0, a_rd_data[15:8]}, 32'h5A);
        check("R3", "b mirror", {24'd0, b_rd_data[7:0]}, 32'h5A);

        cur_req = "R4 R6 full word with ignored bits";
        b_wr(4'b1111, 32'h0080_C3FF);
        check("R6", "b word", b_rd_data, 32'h0000_C35A);
        check("R3", "a mirror", a_rd_data, 32'h0000_5AC3);

        cur_req = "R4 ignored lanes";
        a_wr(4'b0001, 32'h0000_00FF);
        a_wr(4'b0100, 32'h00FF_0000);
        a_wr(4'b1001, 32'h0000_1100);
        check("R4", "a word after narrow writes", a_rd_data, 32'h0000_5AC3);

        cur_req = "R5 enable";
        a_wr(4'b1000, 32'h8000_0000);
        check("R5", "a enable", {31'd0, a_rd_data[31]}, 32'h1);

        cur_req = "R7 B triggers A";
        b_wr(4'b1000, 32'h4000_0000);
        check("R7", "a_irq", {31'd0, a_irq}, 32'h1);
        check("R6", "trigger reads 0", {30'd0, b_rd_data[30:29]}, 32'h0);
        idle();

        cur_req = "R10 mask and unmask";
        a_wr(4'b1000, 32'h0000_0000);
        check("R10", "a_irq masked", {31'd0, a_irq}, 32'h0);
        a_wr(4'b1000, 32'h8000_0000);
        check("R10", "a_irq unmasked", {31'd0, a_irq}, 32'h1);

        cur_req = "R11 acknowledge";
        cyc(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 4'h0, 32'h0, 1'b0);
        check("R11", "a_irq after ack", {31'd0, a_irq}, 32'h0);
        cyc(1'b0, 4'h0, 32'h0, 1'b1, 1'b1, 4'b1000, 32'h4000_0000, 1'b0);
        check("R11", "trigger beats ack", {31'd0, a_irq}, 32'h1);
        cyc(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 4'h0, 32'h0, 1'b0);

        cur_req = "R9 trigger while disabled";
        a_wr(4'b1000, 32'hA000_0000);
        check("R9", "b_irq disabled", {31'd0, b_irq}, 32'h0);
        b_wr(4'b1000, 32'h8000_0000);
        idle();
        check("R9", "b_irq after late enable", {31'd0, b_irq}, 32'h0);

        cur_req = "R8 A triggers B";
        a_wr(4'b1000, 32'hA000_0000);
        check("R8", "b_irq", {31'd0, b_irq}, 32'h1);
        check("R8", "a_irq untouched", {31'd0, a_irq}, 32'h0);
        cyc(1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 4'h0, 32'h0, 1'b1);

        cur_req = "R12 self and simultaneous";
        a_wr(4'b1000, 32'hC000_0000);
        check("R12", "a self trigger", {31'd0, a_irq}, 32'h1);
        cyc(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 4'h0, 32'h0, 1'b0);
        cyc(1'b1, 4'b1000, 32'hE000_0000, 1'b0, 1'b1, 4'b1000, 32'hE000_0000, 1'b0);
        check("R12", "both irqs", {30'd0, a_irq, b_irq}, 32'h3);
        cyc(1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 4'h0, 32'h0, 1'b1);

        cur_req = "R2 R3 R4 R7 R8 R11 random traffic";
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            cyc(($urandom % 3) == 0, 4'($urandom), ra, ($urandom % 5) == 0,
                ($urandom % 3) == 0, 4'($urandom), rb, ($urandom % 5) == 0);
        end

        summary();
    end
endmodule